// File: doc/BRIEF.md
# Keyed-Access Watchdog Timer

This block is a watchdog timer behind a four-word 32-bit register interface. Software must write a pair of magic key words to the counter register before the block accepts any new configuration. It must write a second pair of key words to restart the count. The key words can be written as two 16-bit halves. When the wide-command control bit is set, each pair can instead be written as one 32-bit word.

The counter is driven by one of four tick strobes, chosen by a control field. An optional divide-by-256 prescaler can sit between the strobe and the counter. When the count reaches the programmed timeout, the block raises a sticky flag and requests a system reset. If the interrupt enable bit is set, the block raises an interrupt first and requests the reset a fixed number of ticks later. Misuse of the keys, or a refresh that arrives too early inside a programmed window, also requests a reset at once.

The register port is a plain single-cycle write strobe with a combinational read of the addressed word. It has no handshake and no back-pressure. Every write is taken in the cycle it is presented.

Top module: `keyed_wdt`

## Requirements
- R1: After reset, the control word reads 0x00000420 (update-allowed bit 5 and reconfig-done bit 10 set). The timeout reads 0x03E8, and the window and counter read 0.
- R2: While the block is locked (bit 11 = 0), writes to the timeout (word 2) and window (word 3) registers, and to every control field except the flag, leave them unchanged.
- R3: With bit 13 clear, writing 0xC520 and then 0xD928 to the counter register (word 1) sets bit 11 and clears bit 10.
- R4: With bit 13 set, a single write of 0xD928C520 to the counter register unlocks the block.
- R5: A control write (word 0) while unlocked takes effect at once. It also clears bit 11, sets bit 10 and clears the counter.
- R6: If no control write arrives, the unlocked state closes on its own 255 clocks after the unlock.
- R7: If a control write made while unlocked clears bit 5, every later unlock attempt is ignored until reset.
- R8: A refresh clears the counter. With bit 13 clear, a refresh is 0xA602 then 0xB480. With bit 13 set, it is the single word 0xB480A602.
- R9: With bit 13 clear, a first key half followed by any other counter write gives a one-cycle reset request in the clock of that write.
- R10: With a nonzero window, a refresh while the counter is below the window value gives a reset request instead of a refresh. A refresh at or above the window value is accepted.
- R11: With counting enabled (bit 7) and interrupts off, the tick on which the counter equals the timeout sets the flag (bit 14) and gives a one-cycle reset request. For a timeout of T, this happens T+1 ticks after the count starts.
- R12: With interrupt enable (bit 6) set, a timeout raises the interrupt and no reset. The reset request follows 128 ticks later. Writing 1 to bit 14 clears the flag and drops the interrupt, even while locked.
- R13: Bits 9:8 select which tick strobe drives the counter. Bit 12 divides the selected strobe by 256.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and logic clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 2 | Word index (byte offset bits 3:2) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed word |
| tick_i | input | 4 | Tick strobes, one per clock source |
| irq_o | output | 1 | Timeout interrupt (flag and enable) |
| rst_req_o | output | 1 | One-cycle reset request |

## Verification
The bound checker watches the lock on every cycle. It checks that a locked timeout write leaves the value unchanged and that the unlocked state never outlives its 255-clock limit. It also checks that a control write closes the unlocked state and raises the reconfig-done bit, and that a permanent lock keeps the block locked. The exact timing of the timeout, the 128-tick delayed reset, the prescaler division and the window rule is shown only by the bench scenarios. Those scenarios count cycles from a known configuration write. The same holds for the key sequences in both write widths and the ignored unlock after a permanent lock.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_CNT  = 2'd1;
  localparam logic [1:0] A_TOV  = 2'd2;
  localparam logic [1:0] A_WIN  = 2'd3;

  localparam logic [15:0] REF_LO = 16'hA602;
  localparam logic [15:0] REF_HI = 16'hB480;
  localparam logic [15:0] UNL_LO = 16'hC520;
  localparam logic [15:0] UNL_HI = 16'hD928;

  localparam int B_UPD   = 5;
  localparam int B_INTE  = 6;
  localparam int B_EN    = 7;
  localparam int B_SEL   = 8;
  localparam int B_RCS   = 10;
  localparam int B_ULK   = 11;
  localparam int B_PRES  = 12;
  localparam int B_CMD32 = 13;
  localparam int B_FLG   = 14;

  typedef enum logic [1:0] {KS_IDLE, KS_REF, KS_UNL} key_st_e;
endpackage

// File: rtl/wdt_keyseq.sv
module wdt_keyseq
  import wdt_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr,
  input  logic [31:0] wdata,
  input  logic        wide,
  output logic        refresh_p,
  output logic        unlock_p,
  output logic        key_err_p
);
  key_st_e st_q;
  logic [15:0] lo;
  assign lo = wdata[15:0];

  always_comb begin
    refresh_p = 1'b0;
    unlock_p  = 1'b0;
    key_err_p = 1'b0;
    if (wr) begin
      if (wide) begin
        refresh_p = (wdata == {REF_HI, REF_LO});
        unlock_p  = (wdata == {UNL_HI, UNL_LO});
      end else begin
        case (st_q)
          KS_REF: begin
            refresh_p = (lo == REF_HI);
            key_err_p = (lo != REF_HI);
          end
          KS_UNL: begin
            unlock_p  = (lo == UNL_HI);
            key_err_p = (lo != UNL_HI);
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= KS_IDLE;
    else if (wr) begin
      if (!wide && st_q == KS_IDLE && lo == REF_LO) st_q <= KS_REF;
      else if (!wide && st_q == KS_IDLE && lo == UNL_LO) st_q <= KS_UNL;
      else st_q <= KS_IDLE;
    end
  end
endmodule

// File: rtl/wdt_tick.sv
module wdt_tick #(
  parameter int unsigned NSRC = 4,
  parameter int unsigned PRESC_DIV = 256,
  localparam int unsigned SW = $clog2(NSRC)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] tick_i,
  input  logic [SW-1:0]   sel,
  input  logic            pres_en,
  input  logic            clr,
  output logic            tick_o
);
  logic src;
  assign src = tick_i[sel];

  generate
    if (PRESC_DIV > 1) begin : g_div
      localparam int unsigned PW = $clog2(PRESC_DIV);
      logic [PW-1:0] pcnt_q;
      logic wrap;
      assign wrap = (pcnt_q == PW'(PRESC_DIV - 1));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pcnt_q <= '0;
        else if (clr) pcnt_q <= '0;
        else if (pres_en && src) pcnt_q <= wrap ? '0 : pcnt_q + 1'b1;
      end
      assign tick_o = pres_en ? (src && wrap) : src;
    end else begin : g_nodiv
      assign tick_o = src;
    end
  endgenerate
endmodule

// File: rtl/wdt_timer.sv
module wdt_timer #(
  parameter int unsigned TO_W = 16,
  parameter int unsigned DELAY_TICKS = 128,
  localparam int unsigned DW = $clog2(DELAY_TICKS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            tick,
  input  logic            clr,
  input  logic            int_en,
  input  logic [TO_W-1:0] toval,
  output logic [TO_W-1:0] cnt,
  output logic            to_evt,
  output logic            dly_evt
);
  logic [TO_W-1:0] cnt_q;
  logic [DW-1:0]   dly_q;
  logic            pend_q;
  logic            step;

  assign step    = en && tick && !clr;
  assign to_evt  = step && !pend_q && (cnt_q == toval);
  assign dly_evt = step && pend_q && (dly_q == DW'(DELAY_TICKS - 1));
  assign cnt     = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      dly_q  <= '0;
      pend_q <= 1'b0;
    end else if (clr) begin
      cnt_q  <= '0;
      dly_q  <= '0;
      pend_q <= 1'b0;
    end else if (step) begin
      if (pend_q) begin
        if (dly_evt) begin
          pend_q <= 1'b0;
          dly_q  <= '0;
        end else dly_q <= dly_q + 1'b1;
      end else if (to_evt) begin
        cnt_q  <= '0;
        dly_q  <= '0;
        pend_q <= int_en;
      end else cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt
  import wdt_pkg::*;
#(
  parameter int unsigned TO_W = 16,
  parameter int unsigned RST_TIMEOUT = 1000,
  parameter int unsigned UNLOCK_CYCLES = 255,
  parameter int unsigned DELAY_TICKS = 128,
  parameter int unsigned PRESC_DIV = 256,
  localparam int unsigned AGE_W = $clog2(UNLOCK_CYCLES + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_we,
  input  logic [1:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic [3:0]  tick_i,
  output logic        irq_o,
  output logic        rst_req_o
);
  logic            upd_q, inte_q, en_q, pres_q, cmd32_q, flg_q;
  logic [1:0]      sel_q;
  logic            ulk_q, rcs_q, perm_lock_q;
  logic [AGE_W-1:0] age_q;
  logic [TO_W-1:0] toval_q, win_q, cnt;

  logic wr_ctrl, wr_cnt, wr_tov, wr_win, cfg_ctrl;
  logic refresh_p, unlock_p, key_err_p;
  logic win_viol, refresh_ok, tick, to_evt, dly_evt, tmr_clr;

  assign wr_ctrl  = bus_we && bus_addr == A_CTRL;
  assign wr_cnt   = bus_we && bus_addr == A_CNT;
  assign wr_tov   = bus_we && bus_addr == A_TOV;
  assign wr_win   = bus_we && bus_addr == A_WIN;
  assign cfg_ctrl = wr_ctrl && ulk_q;

  wdt_keyseq i_keys (
    .clk(clk), .rst_n(rst_n), .wr(wr_cnt), .wdata(bus_wdata), .wide(cmd32_q),
    .refresh_p(refresh_p), .unlock_p(unlock_p), .key_err_p(key_err_p)
  );

  assign win_viol   = refresh_p && (win_q != '0) && (cnt < win_q);
  assign refresh_ok = refresh_p && !win_viol;
  assign tmr_clr    = cfg_ctrl || refresh_ok;

  wdt_tick #(.NSRC(4), .PRESC_DIV(PRESC_DIV)) i_tick (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .sel(sel_q),
    .pres_en(pres_q), .clr(tmr_clr), .tick_o(tick)
  );

  wdt_timer #(.TO_W(TO_W), .DELAY_TICKS(DELAY_TICKS)) i_tmr (
    .clk(clk), .rst_n(rst_n), .en(en_q), .tick(tick), .clr(tmr_clr),
    .int_en(inte_q), .toval(toval_q), .cnt(cnt), .to_evt(to_evt), .dly_evt(dly_evt)
  );

  // configuration and lock state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upd_q <= 1'b1; inte_q <= 1'b0; en_q <= 1'b0; pres_q <= 1'b0;
      cmd32_q <= 1'b0; sel_q <= 2'd0;
      toval_q <= TO_W'(RST_TIMEOUT); win_q <= '0;
      ulk_q <= 1'b0; rcs_q <= 1'b1; perm_lock_q <= 1'b0; age_q <= '0;
    end else begin
      if (ulk_q) begin
        age_q <= age_q + 1'b1;
        if (age_q == AGE_W'(UNLOCK_CYCLES - 1)) ulk_q <= 1'b0;
      end
      if (unlock_p && !perm_lock_q) begin
        ulk_q <= 1'b1;
        age_q <= '0;
        rcs_q <= 1'b0;
      end
      if (cfg_ctrl) begin
        upd_q   <= bus_wdata[B_UPD];
        inte_q  <= bus_wdata[B_INTE];
        en_q    <= bus_wdata[B_EN];
        sel_q   <= bus_wdata[B_SEL +: 2];
        pres_q  <= bus_wdata[B_PRES];
        cmd32_q <= bus_wdata[B_CMD32];
        ulk_q   <= 1'b0;
        rcs_q   <= 1'b1;
        if (!bus_wdata[B_UPD]) perm_lock_q <= 1'b1;
      end
      if (wr_tov && ulk_q) toval_q <= bus_wdata[TO_W-1:0];
      if (wr_win && ulk_q) win_q <= bus_wdata[TO_W-1:0];
    end
  end

  // timeout flag and reset request
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flg_q     <= 1'b0;
      rst_req_o <= 1'b0;
    end else begin
      if (to_evt) flg_q <= 1'b1;
      else if (wr_ctrl && bus_wdata[B_FLG]) flg_q <= 1'b0;
      rst_req_o <= key_err_p || win_viol || (to_evt && !inte_q) || dly_evt;
    end
  end

  assign irq_o = flg_q && inte_q;

  always_comb begin
    case (bus_addr)
      A_CTRL: bus_rdata = {17'd0, flg_q, cmd32_q, pres_q, ulk_q, rcs_q, sel_q,
                           en_q, inte_q, upd_q, 5'd0};
      A_CNT:  bus_rdata = {{(32-TO_W){1'b0}}, cnt};
      A_TOV:  bus_rdata = {{(32-TO_W){1'b0}}, toval_q};
      default: bus_rdata = {{(32-TO_W){1'b0}}, win_q};
    endcase
  end
endmodule

// File: rtl/wdt_chk.sv
module wdt_chk #(
  parameter int unsigned TO_W = 16,
  parameter int unsigned AGE_W = 8,
  parameter int unsigned UNLOCK_CYCLES = 255
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_we,
  input logic [1:0]       bus_addr,
  input logic             ulk,
  input logic             rcs,
  input logic             perm_lock,
  input logic [AGE_W-1:0] age,
  input logic [TO_W-1:0]  toval
);
  AST_TOVAL_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (!ulk && bus_we && bus_addr == 2'd2) |=> $stable(toval)); // R2
  AST_ULK_CLEARS_RCS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ulk) |-> !rcs); // R3
  AST_CTRL_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    (ulk && bus_we && bus_addr == 2'd0) |=> !ulk); // R5
  AST_CTRL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (ulk && bus_we && bus_addr == 2'd0) |=> rcs); // R5
  AST_UNLOCK_AGE: assert property (@(posedge clk) disable iff (!rst_n)
    ulk |-> (int'(age) < int'(UNLOCK_CYCLES))); // R6
  AST_STICKY_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (perm_lock && !ulk) |=> !ulk); // R7
endmodule

bind keyed_wdt wdt_chk #(.TO_W(TO_W), .AGE_W(AGE_W), .UNLOCK_CYCLES(UNLOCK_CYCLES)) i_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
  .ulk(ulk_q), .rcs(rcs_q), .perm_lock(perm_lock_q), .age(age_q), .toval(toval_q)
);

// File: tb/test_keyed_wdt.sv
module test_keyed_wdt;
  logic clk = 0, rst_n = 0, bus_we = 0;
  logic [1:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic [3:0] tick_i = 4'b0001;
  logic irq_o, rst_req_o;
  int n_chk = 0, n_bad = 0, cyc = 0;

  always #5 clk = ~clk;

  keyed_wdt i_keyed_wdt (.clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_i(tick_i), .irq_o(irq_o),
    .rst_req_o(rst_req_o));

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; bus_we = 0; tick_i = 4'b0001;
    repeat (2) @(negedge clk); rst_n = 1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); bus_we = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #2; bus_we = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic unlock16();
    wr(2'd1, 32'hC520); wr(2'd1, 32'hD928);
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  // count edges from now until rst_req_o is seen
  task automatic wait_rst(output int n);
    n = 0;
    do begin @(posedge clk); #2; n++; end while (!rst_req_o && n < 2000);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    do_reset();
    rd(2'd0, v); chk("R1 ctrl", v, 32'h420);
    rd(2'd2, v); chk("R1 toval", v, 32'h3E8);
    rd(2'd3, v); chk("R1 win", v, 0);
    rd(2'd1, v); chk("R1 cnt", v, 0);
  endtask

  task automatic t_locked();
    logic [31:0] v;
    do_reset();
    wr(2'd2, 32'h5); wr(2'd3, 32'h9); wr(2'd0, 32'h20A0);
    rd(2'd2, v); chk("R2 toval", v, 32'h3E8);
    rd(2'd3, v); chk("R2 win", v, 0);
    rd(2'd0, v); chk("R2 ctrl", v, 32'h420);
  endtask

  task automatic t_unlock();
    logic [31:0] v;
    do_reset();
    unlock16();
    rd(2'd0, v); chk("R3 ulk", v[11], 1); chk("R3 rcs", v[10], 0);
    wr(2'd2, 32'h40); wr(2'd0, 32'hA0);
    rd(2'd1, v); chk("R5 cnt cleared", v, 0);
    rd(2'd0, v); chk("R5 ctrl", v, 32'h4A0);
    rd(2'd2, v); chk("R5 toval", v, 32'h40);
    unlock16(); idle(250);
    rd(2'd0, v); chk("R6 still open", v[11], 1);
    idle(10);
    rd(2'd0, v); chk("R6 closed", v[11], 0);
  endtask

  task automatic t_wide();
    logic [31:0] v;
    do_reset();
    unlock16(); wr(2'd2, 32'h200); wr(2'd0, 32'h20A0);
    idle(10);
    wr(2'd1, 32'hB480A602);
    rd(2'd1, v); chk("R8 wide refresh", v, 0);
    chk("R8 no reset", rst_req_o, 0);
    wr(2'd1, 32'hD928C520);
    rd(2'd0, v); chk("R4 wide unlock", v[11], 1);
  endtask

  task automatic t_perm();
    logic [31:0] v;
    do_reset();
    unlock16(); wr(2'd0, 32'h0);
    unlock16();
    rd(2'd0, v); chk("R7 unlock ignored", v[11], 0);
    wr(2'd2, 32'h7);
    rd(2'd2, v); chk("R7 toval kept", v, 32'h3E8);
  endtask

  task automatic t_refresh16();
    logic [31:0] v;
    do_reset();
    unlock16(); wr(2'd2, 32'h100); wr(2'd0, 32'hA0);
    idle(20);
    rd(2'd1, v); chk("R8 counting", (v != 0), 1);
    wr(2'd1, 32'hA602); wr(2'd1, 32'hB480);
    rd(2'd1, v); chk("R8 refresh16", v, 0);
    wr(2'd1, 32'hA602); wr(2'd1, 32'h1234);
    chk("R9 bad key", rst_req_o, 1);
    idle(1); chk("R9 one cycle", rst_req_o, 0);
  endtask

  task automatic t_window();
    logic [31:0] v;
    do_reset();
    unlock16(); wr(2'd3, 32'h40); wr(2'd2, 32'h100); wr(2'd0, 32'hA0);
    wr(2'd1, 32'hA602); wr(2'd1, 32'hB480);
    chk("R10 early refresh", rst_req_o, 1);
    idle(80);
    wr(2'd1, 32'hA602); wr(2'd1, 32'hB480);
    chk("R10 late refresh", rst_req_o, 0);
    rd(2'd1, v); chk("R10 cnt cleared", v, 0);
  endtask

  task automatic t_timeout();
    logic [31:0] v;
    int n;
    do_reset();
    unlock16(); wr(2'd2, 32'h5); wr(2'd0, 32'hA0);
    wait_rst(n); chk("R11 timeout ticks", n, 6);
    chk("R11 no irq", irq_o, 0);
    idle(1); chk("R11 one cycle", rst_req_o, 0);
    rd(2'd0, v); chk("R11 flag", v[14], 1);
  endtask

  task automatic t_irq();
    logic [31:0] v;
    int n;
    do_reset();
    unlock16(); wr(2'd2, 32'h3); wr(2'd0, 32'hE0);
    n = 0;
    do begin @(posedge clk); #2; n++; end while (!irq_o && n < 50);
    chk("R12 irq time", n, 4);
    chk("R12 no reset at irq", rst_req_o, 0);
    wait_rst(n); chk("R12 delayed reset", n, 128);
    wr(2'd0, 32'h4000);
    chk("R12 irq cleared", irq_o, 0);
    rd(2'd0, v); chk("R12 flag cleared", v[14], 0);
  endtask

  task automatic t_clk();
    logic [31:0] v;
    int n;
    do_reset();
    unlock16(); wr(2'd2, 32'h1); wr(2'd0, 32'h10A0);
    wait_rst(n); chk("R13 prescaled", n, 512);
    do_reset();
    unlock16(); wr(2'd2, 32'h100); wr(2'd0, 32'h2A0);
    idle(50);
    rd(2'd1, v); chk("R13 other source idle", v, 0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); tick_i[2] = 1; @(negedge clk); tick_i[2] = 0;
    end
    rd(2'd1, v); chk("R13 selected source", v, 3);
  endtask

  initial begin
    t_reset();
    t_locked();
    t_unlock();
    t_wide();
    t_perm();
    t_refresh16();
    t_window();
    t_timeout();
    t_irq();
    t_clk();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule